// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional buses, A and B, and keeps one storage register for each direction of transfer. The A-to-B register samples bus A on the rising edge of its own capture clock. The B-to-A register samples bus B on the rising edge of a second, independent capture clock. Neither capture clock is gated by the enable or the direction input, so either register can be loaded at any moment, including while both buses are released.

An active-low output enable and a direction input select which bus, if any, the block drives. Only one bus is ever driven at a time. For each direction, a select input chooses what is driven: the live value from the opposite bus, passed through combinationally, or the contents of that direction's register. Both paths are non-inverting.

Each bus is split into an input vector, an output vector and a per-bit output-enable vector, so the block can be synthesized as ordinary logic. The pad ring combines these vectors into the physical bus.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage registers are cleared to zero asynchronously. After reset, reading either register through its stored path returns 0x00.
- R2: A rising edge on `clk_ab` loads the current `a_in` value into the A-to-B register.
- R3: A rising edge on `clk_ba` loads the current `b_in` value into the B-to-A register.
- R4: When `oe_n` is 1, `a_oe` and `b_oe` are all zeros and `a_out` and `b_out` read 0x00.
- R5: When `oe_n` is 0 and `dir` is 1, bus B is driven: `b_oe` is all ones and `a_oe` is all zeros.
- R6: When `oe_n` is 0 and `dir` is 0, bus A is driven: `a_oe` is all ones and `b_oe` is all zeros.
- R7: While B is driven, `b_out` equals `a_in` in the same cycle, without inversion, when `sel_ab` is 0. It equals the A-to-B register when `sel_ab` is 1. When B is not driven, `b_out` reads 0x00.
- R8: While A is driven, `a_out` equals `b_in` in the same cycle, without inversion, when `sel_ba` is 0. It equals the B-to-A register when `sel_ba` is 1. When A is not driven, `a_out` reads 0x00.
- R9: Captures on either clock take effect whatever the values of `oe_n` and `dir`, including while both buses are released. Both registers can be loaded in the same disabled interval.
- R10: `a_oe` and `b_oe` are never both nonzero. Each of them is always either all ones or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| clk_ab | input | 1 | Capture clock of the A-to-B register (rising edge) |
| clk_ba | input | 1 | Capture clock of the B-to-A register (rising edge) |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1 drives bus B, 0 drives bus A |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A-to-B |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B-to-A |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Value to drive onto bus A |
| a_oe | output | 8 | Per-bit drive enable for bus A |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Value to drive onto bus B |
| b_oe | output | 8 | Per-bit drive enable for bus B |

## Verification
The hardest case to reach is a value that was captured while both buses were released and that must later appear unchanged once the stored path is selected. The stimulus loads both registers with distinct patterns while `oe_n` is high. It then checks that the outputs stay quiet, and afterwards enables each direction in turn with its select set to the stored path. A second difficult case is a capture edge that coincides with the stored path being driven. The vector table covers it by pulsing the capture clock and reading the new contents in the same step. Live-path tracking is checked by changing the source bus with no clock edge and sampling a fraction of a nanosecond later.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    // which bus, if any, the block is driving
    typedef enum logic [1:0] {
        ROUTE_OFF  = 2'd0,
        ROUTE_TO_A = 2'd1,
        ROUTE_TO_B = 2'd2
    } route_e;

    // source for a driven bus
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

    // index of each direction in per-direction arrays
    localparam int unsigned DIR_AB = 0;
    localparam int unsigned DIR_BA = 1;
    localparam int unsigned N_DIR  = 2;

endpackage

// File: rtl/regbus_store.sv
module regbus_store #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] data;
    } store_t;

    store_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.data = din_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_o = state_q.data;

    AST_CAPTURE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (q_o == $past(din_i))); // R2 R3

endmodule

// File: rtl/regbus_pick.sv
module regbus_pick
    import regbus_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         en_i,
    input  src_e         src_i,
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] stored_i,
    output logic [W-1:0] data_o,
    output logic [W-1:0] oe_o
);

    logic [W-1:0] chosen;

    always_comb begin
        chosen = (src_i == SRC_STORED) ? stored_i : live_i;
        data_o = en_i ? chosen : '0;
        oe_o   = {W{en_i}};
    end

endmodule

// File: rtl/regbus_route.sv
module regbus_route
    import regbus_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         oe_ni,
    input  logic         dir_i,
    input  logic         sel_ab_i,
    input  logic         sel_ba_i,
    input  logic [W-1:0] a_in_i,
    input  logic [W-1:0] b_in_i,
    input  logic [W-1:0] ab_q_i,
    input  logic [W-1:0] ba_q_i,
    output logic [W-1:0] a_out_o,
    output logic [W-1:0] a_oe_o,
    output logic [W-1:0] b_out_o,
    output logic [W-1:0] b_oe_o
);

    route_e route;
    logic   drive_a, drive_b;
    src_e   src_ab, src_ba;

    always_comb begin
        if (oe_ni) begin
            route = ROUTE_OFF;
        end else if (dir_i) begin
            route = ROUTE_TO_B;
        end else begin
            route = ROUTE_TO_A;
        end
        drive_a = (route == ROUTE_TO_A);
        drive_b = (route == ROUTE_TO_B);
        src_ab  = src_e'(sel_ab_i);
        src_ba  = src_e'(sel_ba_i);
    end

    regbus_pick #(.W(W)) u_pick_b (
        .en_i     (drive_b),
        .src_i    (src_ab),
        .live_i   (a_in_i),
        .stored_i (ab_q_i),
        .data_o   (b_out_o),
        .oe_o     (b_oe_o)
    );

    regbus_pick #(.W(W)) u_pick_a (
        .en_i     (drive_a),
        .src_i    (src_ba),
        .live_i   (b_in_i),
        .stored_i (ba_q_i),
        .data_o   (a_out_o),
        .oe_o     (a_oe_o)
    );

    always_comb begin
        AST_ONE_BUS: assert (!((|a_oe_o) && (|b_oe_o))); // R10
        AST_OE_UNIFORM: assert ((a_oe_o == '0 || a_oe_o == '1) && (b_oe_o == '0 || b_oe_o == '1)); // R10
    end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import regbus_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    logic [N_DIR-1:0] cap_clk;
    logic [W-1:0]     src    [N_DIR];
    logic [W-1:0]     stored [N_DIR];

    assign cap_clk[DIR_AB] = clk_ab;
    assign cap_clk[DIR_BA] = clk_ba;
    assign src[DIR_AB]     = a_in;
    assign src[DIR_BA]     = b_in;

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        regbus_store #(.W(W)) u_store (
            .clk_i  (cap_clk[d]),
            .rst_ni (rst_n),
            .din_i  (src[d]),
            .q_o    (stored[d])
        );
    end

    regbus_route #(.W(W)) u_route (
        .oe_ni    (oe_n),
        .dir_i    (dir),
        .sel_ab_i (sel_ab),
        .sel_ba_i (sel_ba),
        .a_in_i   (a_in),
        .b_in_i   (b_in),
        .ab_q_i   (stored[DIR_AB]),
        .ba_q_i   (stored[DIR_BA]),
        .a_out_o  (a_out),
        .a_oe_o   (a_oe),
        .b_out_o  (b_out),
        .b_oe_o   (b_oe)
    );

    always_comb begin
        if (oe_n) begin
            AST_QUIET_WHEN_OFF: assert (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0); // R4
        end
        if (!oe_n && dir) begin
            AST_DRIVE_B: assert (b_oe == '1 && a_oe == '0); // R5
        end
        if (!oe_n && !dir) begin
            AST_DRIVE_A: assert (a_oe == '1 && b_oe == '0); // R6
        end
    end

endmodule

// File: tb/regbus_xcvr_tb.sv
`timescale 1ns/1ps
module regbus_xcvr_tb_top;

    localparam int unsigned W = 8;

    typedef struct packed {
        logic         cap_ab;
        logic         cap_ba;
        logic         oe_n;
        logic         dir;
        logic         sel_ab;
        logic         sel_ba;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } vec_t;

    localparam int N_VEC = 10;
    localparam vec_t VECS [N_VEC] = '{
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h5A, 8'h00},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 8'h22},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'hC3},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h81, 8'h00},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h7E},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h42, 8'h99},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00}
    };

    logic         clk = 1'b0;
    logic         rst_n, clk_ab, clk_ba, oe_n, dir, sel_ab, sel_ba;
    logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;
    logic [W-1:0] ab_m, ba_m;
    int           checks = 0;
    int           failures = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    regbus_xcvr #(.W(W)) dut_i (
        .rst_n  (rst_n),
        .clk_ab (clk_ab),
        .clk_ba (clk_ba),
        .oe_n   (oe_n),
        .dir    (dir),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .a_in   (a_in),
        .a_out  (a_out),
        .a_oe   (a_oe),
        .b_in   (b_in),
        .b_out  (b_out),
        .b_oe   (b_oe)
    );

    task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic pulse(input bit do_ab, input bit do_ba);
        #0.5;
        clk_ab = do_ab;
        clk_ba = do_ba;
        if (do_ab) ab_m = a_in;
        if (do_ba) ba_m = b_in;
        #0.5;
        clk_ab = 1'b0;
        clk_ba = 1'b0;
    endtask

    // expected outputs derived from the requirements
    task automatic check_all();
        logic         drv_b, drv_a;
        logic [W-1:0] eb, ea;
        drv_b = !oe_n && dir;
        drv_a = !oe_n && !dir;
        eb = drv_b ? (sel_ab ? ab_m : a_in) : '0;
        ea = drv_a ? (sel_ba ? ba_m : b_in) : '0;
        chk(oe_n ? "R4" : (dir ? "R5" : "R6"), "b_oe", b_oe, {W{drv_b}});
        chk(oe_n ? "R4" : (dir ? "R5" : "R6"), "a_oe", a_oe, {W{drv_a}});
        chk(drv_b ? "R7" : "R4", "b_out", b_out, eb);
        chk(drv_a ? "R8" : "R4", "a_out", a_out, ea);
        chk("R10", "both_enabled", {7'd0, (|a_oe) && (|b_oe)}, 8'd0);
    endtask

    initial begin
        rst_n = 1'b0; clk_ab = 1'b0; clk_ba = 1'b0;
        oe_n = 1'b1; dir = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
        a_in = '0; b_in = '0; ab_m = '0; ba_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state through the stored paths
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        a_in = 8'hEE; b_in = 8'hDD;
        #0.5;
        chk("R1", "b_out stored after reset", b_out, 8'h00);
        dir = 1'b0;
        #0.5;
        chk("R1", "a_out stored after reset", a_out, 8'h00);

        // table walk
        for (int i = 0; i < N_VEC; i++) begin
            @(negedge clk);
            oe_n = VECS[i].oe_n; dir = VECS[i].dir;
            sel_ab = VECS[i].sel_ab; sel_ba = VECS[i].sel_ba;
            a_in = VECS[i].a; b_in = VECS[i].b;
            pulse(VECS[i].cap_ab, VECS[i].cap_ba);
            #0.3;
            check_all();
        end

        // R9: both captures while released, outputs stay quiet, then read back
        @(negedge clk);
        oe_n = 1'b1; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        a_in = 8'h96; b_in = 8'h69;
        pulse(1'b1, 1'b1);
        #0.3;
        chk("R4", "b_out quiet after disabled capture", b_out, 8'h00);
        chk("R4", "a_out quiet after disabled capture", a_out, 8'h00);
        a_in = 8'h00; b_in = 8'h00;
        oe_n = 1'b0; dir = 1'b1;
        #0.3;
        chk("R9", "b_out stored from disabled capture", b_out, 8'h96);
        dir = 1'b0;
        #0.3;
        chk("R9", "a_out stored from disabled capture", a_out, 8'h69);

        // R2 / R3: single-sided captures leave the other register alone
        @(negedge clk);
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        a_in = 8'h0F; b_in = 8'hF0;
        pulse(1'b1, 1'b0);
        #0.3;
        chk("R2", "b_out after clk_ab edge", b_out, 8'h0F);
        dir = 1'b0;
        #0.3;
        chk("R3", "a_out unchanged without clk_ba edge", a_out, 8'h69);
        pulse(1'b0, 1'b1);
        #0.3;
        chk("R3", "a_out after clk_ba edge", a_out, 8'hF0);

        // R7 / R8: live path tracks input changes with no clock edge
        @(negedge clk);
        dir = 1'b1; sel_ab = 1'b0;
        a_in = 8'h33;
        #0.2;
        chk("R7", "b_out live first", b_out, 8'h33);
        a_in = 8'hCC;
        #0.2;
        chk("R7", "b_out live tracks", b_out, 8'hCC);
        dir = 1'b0; sel_ba = 1'b0;
        b_in = 8'h01;
        #0.2;
        chk("R8", "a_out live first", a_out, 8'h01);
        b_in = 8'h80;
        #0.2;
        chk("R8", "a_out live tracks", a_out, 8'h80);

        // R1: asynchronous clear mid-run, no capture edge
        @(negedge clk);
        sel_ab = 1'b1; sel_ba = 1'b1;
        rst_n = 1'b0;
        #0.3;
        chk("R1", "a_out stored after async clear", a_out, 8'h00);
        dir = 1'b1;
        #0.3;
        chk("R1", "b_out stored after async clear", b_out, 8'h00);
        rst_n = 1'b1;

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run_complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule